// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits next to an 8-bit processor core and decides which interrupt the core services next. It watches five request lines. The first is a non-maskable line. Three are maskable restart lines, named 7.5, 6.5 and 5.5. The last is a general request that carries no vector. The block holds a global enable flag and a mask bit for each restart line. It also holds an edge latch for the 7.5 line, which is the only restart line that triggers on an edge.

The core signals each instruction boundary on `boundary_i`. In that cycle the block picks the highest-priority request that is allowed to proceed. One cycle later it presents the result as a single-cycle `take_o` pulse, together with a source code and a fixed vector address. For the general request it instead raises `ext_op_o`, which tells the core to fetch the opcode from external hardware. Accepting any request clears the global enable flag.

The core can also write a control byte, which does three things at once: it updates the masks, it clears the 7.5 latch, and it drives a serial output pin. A status byte is readable at all times; it reports masks, the enable flag, pending restart lines and a serial input pin.

Top module: `prio_vec_intc`

## Requirements
- R1: Priority from highest to lowest: non-maskable line, restart 7.5, restart 6.5, restart 5.5, general request.
- R2: When `take_o` is high, `src_o` and `vec_o` identify the accepted source:
  - non-maskable: src 1, vector 0x0024
  - restart 7.5: src 2, vector 0x003C
  - restart 6.5: src 3, vector 0x0034
  - restart 5.5: src 4, vector 0x002C
  - general request: src 5, vector 0x0000, with `ext_op_o` high
- R3: The non-maskable line is accepted only if it rose after the last time it was low, and is still high at the boundary. It ignores the masks and the enable flag. One rise gives at most one acceptance, and the line must go low before it can be accepted again.
- R4: A rising edge on restart 7.5 sets its latch even while that line is masked. The latch is cleared when restart 7.5 is accepted, or when a control byte with bit 4 set is written. If a new rising edge arrives in the same cycle as a clear, the latch stays set.
- R5: Restart 6.5, restart 5.5 and the general request are level sensitive and active high. They are sampled only at the boundary and are not held if they drop before it.
- R6: The global enable flag:
  - is 0 after reset;
  - is set by `en_set_i` and cleared by `en_clr_i`;
  - is cleared by any acceptance, and this clear wins over `en_set_i` in the same cycle;
  - must be 1 for any source other than the non-maskable line to be accepted.
- R7: A control-byte write with bit 3 set loads the masks from bits 2, 1 and 0 (for 7.5, 6.5 and 5.5 respectively; 1 means masked). With bit 3 clear, the masks are unchanged. All masks are 1 after reset.
- R8: A control-byte write with bit 6 set copies bit 7 to `sout_o`. Otherwise `sout_o` holds its value. It is 0 after reset.
- R9: The status byte `stat_o` has these fields:
  - bit 7: `sin_i`
  - bit 6: the 7.5 latch
  - bit 5: raw restart 6.5 line
  - bit 4: raw restart 5.5 line
  - bit 3: the enable flag
  - bits 2 to 0: the masks for 7.5, 6.5 and 5.5
- R10: Requests are judged only in cycles where `boundary_i` is high. `take_o` is a registered single-cycle pulse in the following cycle. When `take_o` is low, `src_o`, `vec_o` and `ext_op_o` are 0.
- R11: Bit 5 of the control byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request line |
| rq75_i | input | 1 | Restart 7.5 request, rising-edge |
| rq65_i | input | 1 | Restart 6.5 request, level |
| rq55_i | input | 1 | Restart 5.5 request, level |
| ext_rq_i | input | 1 | General non-vectored request, level |
| boundary_i | input | 1 | Core is at an instruction boundary |
| en_set_i | input | 1 | Enable-interrupts instruction executed |
| en_clr_i | input | 1 | Disable-interrupts instruction executed |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_data_i | input | 8 | Control byte |
| sin_i | input | 1 | Serial input pin, shown in status |
| stat_o | output | 8 | Status byte |
| sout_o | output | 1 | Serial output pin |
| take_o | output | 1 | Interrupt accepted pulse |
| src_o | output | 3 | Accepted source code |
| vec_o | output | 16 | Vector address of accepted source |
| ext_op_o | output | 1 | Core must fetch opcode externally |

## Verification
Two functions can act on the 7.5 latch in the same clock: setting it from a new rising edge, and clearing it. The clear comes either from a control-byte write or from acceptance. The bench drives a rising edge on restart 7.5 in exactly the cycle that a control byte with the clear bit is written, and expects the latch to read back as set in the status byte. A second write with the line held high must then clear it. Likewise, the enable instruction and an acceptance are made to coincide, and the enable flag must read 0 afterwards. A full sweep over all request, mask and enable combinations checks the arbitration against a priority model computed in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_EXT  = 3'd5
  } src_e;

  // restart line index: 2 = 7.5, 1 = 6.5, 0 = 5.5
  localparam int NUM_RST = 3;

  // control byte fields
  localparam int CTL_SOD   = 7;
  localparam int CTL_SDE   = 6;
  localparam int CTL_SPARE = 5;
  localparam int CTL_CLR75 = 4;
  localparam int CTL_MEN   = 3;
endpackage

// File: rtl/intc_edge.sv
module intc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic r75_i,
  input  logic ack_nmi_i,
  input  logic ack_r75_i,
  input  logic clr_r75_i,
  output logic nmi_req_o,
  output logic r75_pend_o
);
  logic nmi_q, r75_q, nmi_pend;
  logic nmi_rise, r75_rise;

  assign nmi_rise = nmi_i & ~nmi_q;
  assign r75_rise = r75_i & ~r75_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b0;
      r75_q      <= 1'b0;
      nmi_pend   <= 1'b0;
      r75_pend_o <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      r75_q <= r75_i;
      // must rise and stay high; re-arms only through a low phase
      if (!nmi_i)         nmi_pend <= 1'b0;
      else if (nmi_rise)  nmi_pend <= 1'b1;
      else if (ack_nmi_i) nmi_pend <= 1'b0;
      // a fresh edge beats any clear in the same cycle
      if (r75_rise)                    r75_pend_o <= 1'b1;
      else if (ack_r75_i || clr_r75_i) r75_pend_o <= 1'b0;
    end
  end

  assign nmi_req_o = nmi_pend & nmi_i;
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
  parameter int NRST = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            sod_i,
  input  logic            sde_i,
  input  logic            men_i,
  input  logic [NRST-1:0] mask_i,
  input  logic            en_set_i,
  input  logic            en_clr_i,
  input  logic            ack_i,
  output logic [NRST-1:0] mask_o,
  output logic            ie_o,
  output logic            sout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      ie_o   <= 1'b0;
      sout_o <= 1'b0;
    end else begin
      if (we_i && men_i) mask_o <= mask_i;
      if (we_i && sde_i) sout_o <= sod_i;
      if (ack_i)         ie_o <= 1'b0;
      else if (en_clr_i) ie_o <= 1'b0;
      else if (en_set_i) ie_o <= 1'b1;
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio
  import intc_pkg::*;
#(
  parameter int              NRST     = 3,
  parameter int              VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0024,
  parameter int              VEC_STEP = 8
) (
  input  logic             nmi_req_i,
  input  logic [NRST-1:0]  rst_req_i,
  input  logic             ext_req_i,
  input  logic [NRST-1:0]  mask_i,
  input  logic             ie_i,
  output src_e             win_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NRST-1:0] gated;

  for (genvar g = 0; g < NRST; g++) begin : g_gate
    assign gated[g] = rst_req_i[g] & ~mask_i[g] & ie_i;
  end

  always_comb begin
    win_o = SRC_NONE;
    vec_o = '0;
    if (nmi_req_i) begin
      win_o = SRC_NMI;
      vec_o = VEC_BASE;
    end else begin
      for (int i = 0; i < NRST; i++) begin
        // higher index overwrites lower: 7.5 over 6.5 over 5.5
        if (gated[i]) begin
          win_o = src_e'(3'(int'(SRC_R55) - i));
          vec_o = VEC_BASE + VEC_W'(VEC_STEP * (i + 1));
        end
      end
      if (win_o == SRC_NONE && ext_req_i && ie_i) win_o = SRC_EXT;
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0024,
  parameter int               VEC_STEP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             rq75_i,
  input  logic             rq65_i,
  input  logic             rq55_i,
  input  logic             ext_rq_i,
  input  logic             boundary_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             ctl_we_i,
  input  logic [7:0]       ctl_data_i,
  input  logic             sin_i,
  output logic [7:0]       stat_o,
  output logic             sout_o,
  output logic             take_o,
  output logic [2:0]       src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ext_op_o
);
  localparam int NRST = NUM_RST;

  logic             nmi_req, r75_pend, ie, ack;
  logic [NRST-1:0]  mask, rst_req;
  src_e             win;
  logic [VEC_W-1:0] win_vec;
  logic             unused_spare;

  assign unused_spare = ctl_data_i[CTL_SPARE];
  assign ack = boundary_i && (win != SRC_NONE);

  intc_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nmi_i      (nmi_i),
    .r75_i      (rq75_i),
    .ack_nmi_i  (ack && win == SRC_NMI),
    .ack_r75_i  (ack && win == SRC_R75),
    .clr_r75_i  (ctl_we_i && ctl_data_i[CTL_CLR75]),
    .nmi_req_o  (nmi_req),
    .r75_pend_o (r75_pend)
  );

  intc_ctrl #(.NRST(NRST)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .sod_i    (ctl_data_i[CTL_SOD]),
    .sde_i    (ctl_data_i[CTL_SDE]),
    .men_i    (ctl_data_i[CTL_MEN]),
    .mask_i   (ctl_data_i[NRST-1:0]),
    .en_set_i (en_set_i),
    .en_clr_i (en_clr_i),
    .ack_i    (ack),
    .mask_o   (mask),
    .ie_o     (ie),
    .sout_o   (sout_o)
  );

  assign rst_req = {r75_pend, rq65_i, rq55_i};

  intc_prio #(
    .NRST(NRST), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_prio (
    .nmi_req_i (nmi_req),
    .rst_req_i (rst_req),
    .ext_req_i (ext_rq_i),
    .mask_i    (mask),
    .ie_i      (ie),
    .win_o     (win),
    .vec_o     (win_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o   <= 1'b0;
      src_o    <= 3'd0;
      vec_o    <= '0;
      ext_op_o <= 1'b0;
    end else begin
      take_o   <= ack;
      src_o    <= ack ? 3'(win) : 3'd0;
      vec_o    <= ack ? win_vec : '0;
      ext_op_o <= ack && win == SRC_EXT;
    end
  end

  assign stat_o = {sin_i, r75_pend, rq65_i, rq55_i, ie, mask};
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        boundary_i,
  input logic        nmi_i,
  input logic        ctl_we_i,
  input logic [7:0]  ctl_data_i,
  input logic [7:0]  stat_o,
  input logic        sout_o,
  input logic        take_o,
  input logic [2:0]  src_o,
  input logic [15:0] vec_o,
  input logic        ext_op_o
);
  assert_take_at_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));
  assert_idle_outputs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (src_o == 3'd0 && vec_o == 16'h0 && !ext_op_o));
  assert_vec_r75_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && src_o == 3'd2) |-> vec_o == 16'h003C);
  assert_ext_op_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_op_o |-> (take_o && src_o == 3'd5));
  assert_nmi_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && src_o == 3'd1) |-> $past(nmi_i));
  assert_ack_clears_ie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !stat_o[3]);
  assert_mask_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_we_i && ctl_data_i[3]) |=> $stable(stat_o[2:0]));
  assert_sout_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_we_i && ctl_data_i[6]) |=> $stable(sout_o));
endmodule

bind prio_vec_intc prio_vec_intc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .nmi_i      (nmi_i),
  .ctl_we_i   (ctl_we_i),
  .ctl_data_i (ctl_data_i),
  .stat_o     (stat_o),
  .sout_o     (sout_o),
  .take_o     (take_o),
  .src_o      (src_o),
  .vec_o      (vec_o),
  .ext_op_o   (ext_op_o)
);

// File: tb/prio_vec_intc_test.sv
`timescale 1ns/1ps
module prio_vec_intc_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic nmi_i = 0, rq75_i = 0, rq65_i = 0, rq55_i = 0, ext_rq_i = 0;
  logic boundary_i = 0, en_set_i = 0, en_clr_i = 0, ctl_we_i = 0, sin_i = 0;
  logic [7:0]  ctl_data_i = 8'h00;
  logic [7:0]  stat_o;
  logic        sout_o, take_o, ext_op_o;
  logic [2:0]  src_o;
  logic [15:0] vec_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  prio_vec_intc uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .nmi_i(nmi_i), .rq75_i(rq75_i),
    .rq65_i(rq65_i), .rq55_i(rq55_i), .ext_rq_i(ext_rq_i),
    .boundary_i(boundary_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .ctl_we_i(ctl_we_i), .ctl_data_i(ctl_data_i), .sin_i(sin_i),
    .stat_o(stat_o), .sout_o(sout_o), .take_o(take_o), .src_o(src_o),
    .vec_o(vec_o), .ext_op_o(ext_op_o)
  );

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    ctl_we_i = 1; ctl_data_i = d; cyc(); ctl_we_i = 0; ctl_data_i = 0;
  endtask

  // result word {take, src, vec, ext_op}
  function automatic logic [31:0] res();
    return {11'd0, take_o, src_o, vec_o, ext_op_o};
  endfunction

  function automatic logic [31:0] mk(logic t, logic [2:0] s, logic [15:0] v, logic e);
    return {11'd0, t, s, v, e};
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1;
    cyc();
    // R9 R6 R7 R8 reset state
    chk("R9 reset status", stat_o, 8'h07);
    chk("R8 reset sout", sout_o, 0);
    chk("R10 reset idle", res(), 0);
    sin_i = 1; cyc();
    chk("R9 serial in bit7", stat_o[7], 1);
    sin_i = 0;

    // R8 serial output
    wr(8'hC0); chk("R8 sout set", sout_o, 1);
    wr(8'h00); chk("R8 sout hold without bit6", sout_o, 1);
    wr(8'h40); chk("R8 sout cleared", sout_o, 0);
    chk("R7 masks kept when bit3 low", stat_o[2:0], 3'b111);

    // R11 spare bit
    wr(8'h08); chk("R7 masks loaded", stat_o[2:0], 3'b000);
    wr(8'h20); chk("R11 spare bit no effect", {sout_o, stat_o}, {1'b0, 8'h00});
    wr(8'h07); chk("R7 bit3 low leaves masks", stat_o[2:0], 3'b000);

    // R10 boundary gating
    en_set_i = 1; rq65_i = 1; cyc(); en_set_i = 0;
    chk("R6 enable set", stat_o[3], 1);
    cyc(); cyc();
    chk("R10 no take without boundary", take_o, 0);
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R2 R10 take 6.5", res(), mk(1, 3'd3, 16'h0034, 0));
    chk("R6 take clears enable", stat_o[3], 0);
    cyc();
    chk("R10 single pulse", take_o, 0);
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R6 disabled blocks 6.5", take_o, 0);

    // R6 enable clear, and take wins over set
    en_set_i = 1; cyc(); en_set_i = 0;
    en_clr_i = 1; cyc(); en_clr_i = 0;
    chk("R6 disable clears", stat_o[3], 0);
    en_set_i = 1; cyc();
    boundary_i = 1; cyc(); boundary_i = 0; en_set_i = 0;
    chk("R6 take with set same cycle", {take_o, stat_o[3]}, 2'b10);
    rq65_i = 0;

    // R3 non-maskable
    nmi_i = 1; cyc();
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R3 nmi while disabled", res(), mk(1, 3'd1, 16'h0024, 0));
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R3 nmi held high no retake", take_o, 0);
    nmi_i = 0; cyc(); nmi_i = 1; cyc(); nmi_i = 0; cyc();
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R3 nmi dropped before boundary", take_o, 0);
    nmi_i = 1; cyc();
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R3 nmi re-armed after low", src_o, 3'd1);
    nmi_i = 0; cyc();

    // R4 latch while masked
    wr(8'h0C);
    rq75_i = 1; cyc(); rq75_i = 0; cyc();
    chk("R4 latch set while masked", stat_o[6], 1);
    en_set_i = 1; cyc(); en_set_i = 0;
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R4 masked 7.5 not taken", take_o, 0);
    wr(8'h08);
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R2 R4 take 7.5", res(), mk(1, 3'd2, 16'h003C, 0));
    chk("R4 ack clears latch", stat_o[6], 0);

    // R4 edge and clear in the same cycle
    rq75_i = 1; ctl_we_i = 1; ctl_data_i = 8'h10; cyc();
    chk("R4 edge beats clear", stat_o[6], 1);
    cyc(); ctl_we_i = 0; ctl_data_i = 0;
    chk("R4 clear with line high", stat_o[6], 0);
    rq75_i = 0; cyc();

    // R5 levels not held
    en_set_i = 1; cyc(); en_set_i = 0;
    rq65_i = 1; cyc(); rq65_i = 0; cyc();
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R5 dropped level not taken", take_o, 0);
    wr(8'h09); rq55_i = 1; cyc();
    chk("R9 masked 5.5 pending shown", stat_o[4], 1);
    boundary_i = 1; cyc(); boundary_i = 0;
    chk("R7 masked 5.5 not taken", take_o, 0);
    rq55_i = 0;

    // R1 R2 R3 R5 R6 R7 sweep: lines {nmi,75,65,55,ext}, masks, enable
    for (int v = 0; v < 32; v++) begin
      for (int m = 0; m < 8; m++) begin
        for (int e = 0; e < 2; e++) begin
          logic [31:0] exp_r;
          logic exp_ie, exp_l75;
          nmi_i = 0; rq75_i = 0; rq65_i = 0; rq55_i = 0; ext_rq_i = 0;
          ctl_we_i = 1; ctl_data_i = 8'h18 | 8'(m); en_clr_i = 1; cyc();
          ctl_we_i = 0; ctl_data_i = 0; en_clr_i = 0; en_set_i = 1'(e);
          nmi_i = v[4]; rq75_i = v[3]; rq65_i = v[2]; rq55_i = v[1]; ext_rq_i = v[0];
          cyc();
          en_set_i = 0; boundary_i = 1; cyc(); boundary_i = 0;
          if (v[4])                  exp_r = mk(1, 3'd1, 16'h0024, 0);
          else if (e && v[3] && !m[2]) exp_r = mk(1, 3'd2, 16'h003C, 0);
          else if (e && v[2] && !m[1]) exp_r = mk(1, 3'd3, 16'h0034, 0);
          else if (e && v[1] && !m[0]) exp_r = mk(1, 3'd4, 16'h002C, 0);
          else if (e && v[0])          exp_r = mk(1, 3'd5, 16'h0000, 1);
          else                         exp_r = 0;
          exp_ie  = exp_r[20] ? 1'b0 : 1'(e);
          exp_l75 = (exp_r[19:17] == 3'd2) ? 1'b0 : v[3];
          chk("R1 sweep winner", res(), exp_r);
          chk("R6 R4 sweep enable and latch", {stat_o[6], stat_o[3]}, {exp_l75, exp_ie});
          nmi_i = 0; rq75_i = 0; rq65_i = 0; rq55_i = 0; ext_rq_i = 0;
          cyc();
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule